// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core that runs in six register views: user/system, supervisor, abort, undefined, interrupt and fast interrupt. Software addresses sixteen logical registers. The block steers each access to a physical copy chosen by the current mode code. The fast-interrupt view has private copies of registers 8 to 14. Each of the other exception views has private copies of registers 13 and 14 only. Everything else is shared by all modes. In total the block holds 31 general-purpose words and 6 status words.

Two read ports look up the store combinationally. One write port updates it on the rising clock edge. A current status word is visible in every mode. A separate saved-status port reaches the saved copy that belongs to the present exception mode. Decode, exception sequencing, program-counter arithmetic and flag generation are handled by the surrounding pipeline. That pipeline drives the mode code on `mode_i`, and the code takes effect on all ports in the same cycle.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset sets every general-purpose word and every saved-status word to zero. It also sets the current status word to 32'h0000_0013, which is the supervisor code in bits 4:0.
- R2: Mode codes select register views as follows: 10000 user, 11111 system, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined. Any other code selects the same view as user.
- R3: Logical registers 0 to 7 and 15 are one physical copy each, and every mode reads and writes that copy.
- R4: Logical registers 8 to 12 have one copy private to fast-interrupt mode and one copy shared by all other modes.
- R5: Logical registers 13 and 14 have six copies each: one shared by user and system, and one private to each of the five exception modes.
- R6: Both read ports return, in the same cycle, the word selected by their own index under the current mode. Equal indices give equal data.
- R7: A write through the write port is visible from the cycle after the clock edge. A read of the same physical word in the cycle of the write returns the previous contents.
- R8: The current status word is one copy that all modes see. A write to it is visible from the next cycle.
- R9: Each of the five exception modes has its own saved-status word, which the saved-status port reads and writes while that mode is selected.
- R10: In the user/system view, the saved-status read port returns the current status word, and a saved-status write changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Current mode code selecting the register view |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | DATA_W | Data from read port A |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | DATA_W | Data from read port B |
| wr_en | input | 1 | Write enable for the general-purpose write port |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | DATA_W | Data to write |
| cpsr_we | input | 1 | Write enable for the current status word |
| cpsr_wdata | input | DATA_W | New current status word |
| cpsr_rdata | output | DATA_W | Current status word |
| spsr_we | input | 1 | Write enable for the saved-status word of the current mode |
| spsr_wdata | input | DATA_W | New saved-status word |
| spsr_rdata | output | DATA_W | Saved-status word of the current mode, or the current status word in the user/system view |

## Verification
Read data and the saved-status output are combinational. They are therefore due in the same cycle as the index or mode change. Any write is due one clock edge later. The bench changes every input 1 ns after a rising edge and samples a fraction of a nanosecond later, which keeps all samples well clear of the next edge. Each write is checked only after the edge that commits it. The read-during-write case is sampled twice: once before that edge, where the old word is expected, and once after it, where the new word is expected. The reference model is a per-view shadow table. The bench updates it from the sharing rules of R3 to R5 and sweeps every index in every mode code, including one undefined code.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;

    localparam int XLEN      = 32;
    localparam int MODE_W    = 5;
    localparam int LOG_REGS  = 16;
    localparam int LOG_W     = $clog2(LOG_REGS);

    localparam int SHARED_N  = LOG_REGS;
    localparam int FIQ_N     = 7;
    localparam int PAIR_N    = 2;
    localparam int EXC_PAIRS = 4;
    localparam int PHYS_GPR  = SHARED_N + FIQ_N + EXC_PAIRS * PAIR_N;
    localparam int PHYS_W    = $clog2(PHYS_GPR);
    localparam int SAVED_N   = 5;
    localparam int SAVED_W   = $clog2(SAVED_N);

    localparam int FIQ_BASE  = SHARED_N;
    localparam int SVC_BASE  = FIQ_BASE + FIQ_N;
    localparam int ABT_BASE  = SVC_BASE + PAIR_N;
    localparam int UND_BASE  = ABT_BASE + PAIR_N;
    localparam int IRQ_BASE  = UND_BASE + PAIR_N;

    localparam logic [MODE_W-1:0] CODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] CODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] CODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] CODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] CODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] CODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] CODE_SYS = 5'b11111;
    localparam logic [MODE_W-1:0] RESET_MODE = CODE_SVC;

    typedef enum logic [2:0] {
        VIEW_USR = 3'd0,
        VIEW_FIQ = 3'd1,
        VIEW_IRQ = 3'd2,
        VIEW_SVC = 3'd3,
        VIEW_ABT = 3'd4,
        VIEW_UND = 3'd5
    } view_e;

    typedef struct packed {
        view_e              view;
        logic               has_saved;
        logic [SAVED_W-1:0] saved_sel;
    } view_t;

    function automatic view_e view_of(logic [MODE_W-1:0] code);
        view_e v;
        case (code)
            CODE_FIQ: v = VIEW_FIQ;
            CODE_IRQ: v = VIEW_IRQ;
            CODE_SVC: v = VIEW_SVC;
            CODE_ABT: v = VIEW_ABT;
            CODE_UND: v = VIEW_UND;
            default:  v = VIEW_USR;
        endcase
        return v;
    endfunction

    function automatic logic [PHYS_W-1:0] pair_base(view_e v);
        logic [PHYS_W-1:0] b;
        case (v)
            VIEW_SVC: b = PHYS_W'(SVC_BASE);
            VIEW_ABT: b = PHYS_W'(ABT_BASE);
            VIEW_UND: b = PHYS_W'(UND_BASE);
            VIEW_IRQ: b = PHYS_W'(IRQ_BASE);
            default:  b = PHYS_W'(13);
        endcase
        return b;
    endfunction

    function automatic logic [PHYS_W-1:0] phys_slot(view_e v, logic [LOG_W-1:0] idx);
        logic [PHYS_W-1:0] s;
        s = PHYS_W'(idx);
        if (v == VIEW_FIQ && idx >= 4'd8 && idx <= 4'd14) begin
            s = PHYS_W'(FIQ_BASE) + PHYS_W'(idx - 4'd8);
        end else if (idx == 4'd13 || idx == 4'd14) begin
            s = pair_base(v) + PHYS_W'(idx - 4'd13);
        end
        return s;
    endfunction

endpackage

// File: rtl/mode_decode.sv
`timescale 1ns/1ps
module mode_decode
    import bank_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output view_t             view_o
);

    view_e v;

    always_comb begin
        v = view_of(mode_i);
        view_o.view      = v;
        view_o.has_saved = (v != VIEW_USR);
        view_o.saved_sel = (v != VIEW_USR) ? SAVED_W'(3'(v) - 3'd1) : '0;
    end

endmodule

// File: rtl/slot_map.sv
`timescale 1ns/1ps
module slot_map
    import bank_pkg::*;
#(
    parameter int PORTS = 3
) (
    input  view_e                       view_i,
    input  logic [PORTS-1:0][LOG_W-1:0] idx_i,
    output logic [PORTS-1:0][PHYS_W-1:0] slot_o
);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        always_comb slot_o[p] = phys_slot(view_i, idx_i[p]);
    end

endmodule

// File: rtl/gpr_store.sv
`timescale 1ns/1ps
module gpr_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOTS  = PHYS_GPR,
    parameter int NRD    = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [PHYS_W-1:0]                wr_slot,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NRD-1:0][PHYS_W-1:0]       rd_slot,
    output logic [NRD-1:0][DATA_W-1:0]       rd_data
);

    logic [SLOTS-1:0][DATA_W-1:0] cells;

    for (genvar s = 0; s < SLOTS; s++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_slot == PHYS_W'(s)) begin
                q <= wr_data;
            end
        end
        assign cells[s] = q;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (rd_slot[p] == PHYS_W'(s)) rd_data[p] = cells[s];
            end
        end
    end

endmodule

// File: rtl/status_store.sv
`timescale 1ns/1ps
module status_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSAVED = SAVED_N
) (
    input  logic                clk,
    input  logic                rst,
    input  view_t               view_i,
    input  logic                cur_we,
    input  logic [DATA_W-1:0]   cur_wdata,
    output logic [DATA_W-1:0]   cur_rdata,
    input  logic                saved_we,
    input  logic [DATA_W-1:0]   saved_wdata,
    output logic [DATA_W-1:0]   saved_rdata
);

    localparam logic [DATA_W-1:0] CUR_RESET = {{(DATA_W-MODE_W){1'b0}}, RESET_MODE};

    logic [DATA_W-1:0]              cur_q;
    logic [NSAVED-1:0][DATA_W-1:0]  saved;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= CUR_RESET;
        end else if (cur_we) begin
            cur_q <= cur_wdata;
        end
    end

    for (genvar k = 0; k < NSAVED; k++) begin : g_saved
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (saved_we && view_i.has_saved && view_i.saved_sel == SAVED_W'(k)) begin
                q <= saved_wdata;
            end
        end
        assign saved[k] = q;
    end

    always_comb begin
        cur_rdata   = cur_q;
        saved_rdata = cur_q;
        if (view_i.has_saved) begin
            for (int k = 0; k < NSAVED; k++) begin
                if (view_i.saved_sel == SAVED_W'(k)) saved_rdata = saved[k];
            end
        end
    end

endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [LOG_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [LOG_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [LOG_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpsr_we,
    input  logic [DATA_W-1:0] cpsr_wdata,
    output logic [DATA_W-1:0] cpsr_rdata,
    input  logic              spsr_we,
    input  logic [DATA_W-1:0] spsr_wdata,
    output logic [DATA_W-1:0] spsr_rdata
);

    localparam int NRD   = 2;
    localparam int NMAP  = NRD + 1;

    view_t                        view;
    logic [NMAP-1:0][LOG_W-1:0]   map_idx;
    logic [NMAP-1:0][PHYS_W-1:0]  map_slot;
    logic [NRD-1:0][PHYS_W-1:0]   rd_slot;
    logic [NRD-1:0][DATA_W-1:0]   rd_data;

    mode_decode u_decode (
        .mode_i (mode_i),
        .view_o (view)
    );

    assign map_idx[0] = rd_a_idx;
    assign map_idx[1] = rd_b_idx;
    assign map_idx[2] = wr_idx;

    slot_map #(.PORTS(NMAP)) u_map (
        .view_i (view.view),
        .idx_i  (map_idx),
        .slot_o (map_slot)
    );

    assign rd_slot[0] = map_slot[0];
    assign rd_slot[1] = map_slot[1];

    gpr_store #(.DATA_W(DATA_W), .SLOTS(PHYS_GPR), .NRD(NRD)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (map_slot[2]),
        .wr_data (wr_data),
        .rd_slot (rd_slot),
        .rd_data (rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    status_store #(.DATA_W(DATA_W), .NSAVED(SAVED_N)) u_status (
        .clk         (clk),
        .rst         (rst),
        .view_i      (view),
        .cur_we      (cpsr_we),
        .cur_wdata   (cpsr_wdata),
        .cur_rdata   (cpsr_rdata),
        .saved_we    (spsr_we),
        .saved_wdata (spsr_wdata),
        .saved_rdata (spsr_rdata)
    );

endmodule

// File: rtl/banked_regfile_checker.sv
`timescale 1ns/1ps
module banked_regfile_checker
    import bank_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [LOG_W-1:0]  rd_a_idx,
    input  logic [DATA_W-1:0] rd_a_data,
    input  logic [LOG_W-1:0]  rd_b_idx,
    input  logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [LOG_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpsr_we,
    input  logic [DATA_W-1:0] cpsr_wdata,
    input  logic [DATA_W-1:0] cpsr_rdata,
    input  logic              spsr_we,
    input  logic [DATA_W-1:0] spsr_wdata,
    input  logic [DATA_W-1:0] spsr_rdata
);

    localparam logic [DATA_W-1:0] CUR_RESET = {{(DATA_W-MODE_W){1'b0}}, RESET_MODE};

    logic user_view;
    logic common_idx;

    assign user_view  = (view_of(mode_i) == VIEW_USR);
    assign common_idx = (wr_idx < 4'd8) || (wr_idx == 4'd15);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpsr_rdata == CUR_RESET && rd_a_data == '0));

    assert_common_regs_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(common_idx) && rd_a_idx == $past(wr_idx))
        |-> rd_a_data == $past(wr_data));

    assert_ports_agree_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

    assert_write_visible_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && mode_i == $past(mode_i) && rd_b_idx == $past(wr_idx))
        |-> rd_b_data == $past(wr_data));

    assert_status_write_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cpsr_we)) |-> cpsr_rdata == $past(cpsr_wdata));

    assert_saved_write_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(spsr_we) && !$past(user_view) && mode_i == $past(mode_i))
        |-> spsr_rdata == $past(spsr_wdata));

    assert_user_saved_R10: assert property (@(posedge clk) disable iff (rst)
        user_view |-> spsr_rdata == cpsr_rdata);

endmodule

bind banked_regfile banked_regfile_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cpsr_we    (cpsr_we),
    .cpsr_wdata (cpsr_wdata),
    .cpsr_rdata (cpsr_rdata),
    .spsr_we    (spsr_we),
    .spsr_wdata (spsr_wdata),
    .spsr_rdata (spsr_rdata)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode_i = 5'b10000;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, cpsr_rdata, spsr_rdata;
    logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
    logic [31:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] shadow [6][16];
    logic [31:0] cur_model;
    logic [31:0] saved_model [6];

    always #2.5 clk = ~clk;

    banked_regfile #(.DATA_W(32)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_rdata(cpsr_rdata),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata)
    );

    // Mode codes under test; entry 7 is an undefined code (user view, R2).
    function automatic logic [4:0] code_at(int k);
        case (k)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            default: return 5'b00000;
        endcase
    endfunction

    // View number: 0 user/system/other, 1 fast irq, 2 irq, 3 svc, 4 abort, 5 undefined.
    function automatic int grp(logic [4:0] c);
        case (c)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic bit shares(int g1, int g2, int i);
        if (i < 8 || i == 15) return 1'b1;
        if (i <= 12) return (g1 == 1) == (g2 == 1);
        return g1 == g2;
    endfunction

    function automatic string req_of(int i);
        if (i < 8 || i == 15) return "R3";
        if (i <= 12) return "R4";
        return "R5";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic gpr_write(logic [4:0] code, int idx, logic [31:0] val);
        mode_i  = code;
        wr_idx  = 4'(idx);
        wr_data = val;
        wr_en   = 1'b1;
        step();
        wr_en   = 1'b0;
        for (int g = 0; g < 6; g++) begin
            if (shares(grp(code), g, idx)) shadow[g][idx] = val;
        end
    endtask

    task automatic read_check(logic [4:0] code, int ia, int ib, string tag);
        mode_i   = code;
        rd_a_idx = 4'(ia);
        rd_b_idx = 4'(ib);
        #0.2;
        check(tag == "" ? req_of(ia) : tag, rd_a_data, shadow[grp(code)][ia]);
        check("R6", rd_b_data, shadow[grp(code)][ib]);
    endtask

    task automatic reset_model();
        for (int g = 0; g < 6; g++) begin
            saved_model[g] = '0;
            for (int i = 0; i < 16; i++) shadow[g][i] = '0;
        end
        cur_model = 32'h0000_0013;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        reset_model();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state seen through every view
        check("R1", cpsr_rdata, 32'h0000_0013);
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 16; i++) read_check(code_at(k), i, 15 - i, "R1");
        end
        mode_i = 5'b10011;
        #0.2;
        check("R1", spsr_rdata, 32'h0);

        // Exhaustive sweep: write each index in each mode, read it in every mode (R2..R7)
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 16; i++) begin
                gpr_write(code_at(m), i, 32'hC000_0000 | (m << 20) | (i << 12) | (m * 16 + i + 1));
                for (int k = 0; k < 8; k++) begin
                    read_check(code_at(k), i, (i + k) % 16, k == 7 ? "R2" : "");
                end
            end
        end

        // R5: register 13 written in every defined mode, read in every mode
        for (int m = 0; m < 7; m++) gpr_write(code_at(m), 13, 32'hD000_0000 | code_at(m));
        for (int k = 0; k < 8; k++) begin
            mode_i   = code_at(k);
            rd_a_idx = 4'd13;
            #0.2;
            check("R5", rd_a_data, 32'hD000_0000 | ((grp(code_at(k)) == 0) ? 5'b11111 : code_at(k)));
        end

        // R7: read of the word being written returns old data until the edge
        mode_i   = 5'b10000;
        rd_a_idx = 4'd3;
        rd_b_idx = 4'd3;
        wr_idx   = 4'd3;
        wr_data  = 32'h1234_5678;
        wr_en    = 1'b1;
        #0.2;
        check("R7", rd_a_data, shadow[0][3]);
        step();
        wr_en = 1'b0;
        for (int g = 0; g < 6; g++) shadow[g][3] = 32'h1234_5678;
        check("R7", rd_a_data, 32'h1234_5678);

        // R8: current status word write, seen in every mode
        cpsr_wdata = 32'hF000_00D3;
        cpsr_we    = 1'b1;
        step();
        cpsr_we    = 1'b0;
        cur_model  = 32'hF000_00D3;
        for (int k = 0; k < 8; k++) begin
            mode_i = code_at(k);
            #0.2;
            check("R8", cpsr_rdata, cur_model);
        end

        // R9: each exception mode writes its own saved word
        for (int k = 1; k <= 5; k++) begin
            mode_i     = code_at(k);
            spsr_wdata = 32'hE000_0000 | k;
            spsr_we    = 1'b1;
            step();
            spsr_we    = 1'b0;
            saved_model[grp(code_at(k))] = 32'hE000_0000 | k;
        end
        // R10: saved-status write in user view changes nothing
        mode_i     = 5'b10000;
        spsr_wdata = 32'h0BAD_0BAD;
        spsr_we    = 1'b1;
        step();
        spsr_we    = 1'b0;
        for (int k = 0; k < 8; k++) begin
            mode_i = code_at(k);
            #0.2;
            if (grp(code_at(k)) == 0) check("R10", spsr_rdata, cur_model);
            else                      check("R9", spsr_rdata, saved_model[grp(code_at(k))]);
            check("R10", cpsr_rdata, cur_model);
        end

        // R1: reset in mid-run clears banked and status words
        rst = 1'b1;
        step();
        rst = 1'b0;
        reset_model();
        check("R1", cpsr_rdata, 32'h0000_0013);
        for (int k = 0; k < 8; k++) begin
            read_check(code_at(k), 13, 8, "R1");
            read_check(code_at(k), 14, 15, "R1");
            #0.2;
            check("R1", spsr_rdata, grp(code_at(k)) == 0 ? 32'h0000_0013 : 32'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule